// File: doc/BRIEF.md
# Bus Master Retry and Ready-Wait Abort Monitor

This block sits beside a bus master's sequencer and decides when an outstanding transfer has to be given up. It keeps two independent counts. One counts how many times the target has answered the current transfer with a retry. The other counts how many clock cycles the master has waited in a data phase for the target to signal ready. Each count has its own 8-bit limit. A limit of zero switches that check off (unlimited retries, or no ready-wait timeout).

When either count reaches its limit, the block raises a single-cycle abort pulse toward the sequencer. It also records the cause in one of two sticky flags. Software clears a flag by writing a one to its bit. Both limits are held in registers that load together on a configuration strobe. Both limits and both flags come out of reset at zero, so nothing is aborted until software programs a limit.

Top module: `xfer_abort_monitor`

## Requirements
- R1: After reset both limits and both flags are zero and `abort` is low; with zero limits, no amount of retry or wait activity produces an abort.
- R2: With retry limit N (1..255), the Nth retry counted in one transfer makes `abort` high and sets `retry_abort_flag` in the cycle after that retry is sampled.
- R3: A retry limit of zero never produces a retry abort, however many retries arrive.
- R4: The retry count returns to zero when `txn_start` or `txn_done` is sampled high. A retry sampled in that same cycle is not counted.
- R5: With wait limit N (1..255), the Nth cycle of `trdy_wait` without a reset of the count makes `abort` high and sets `wait_abort_flag` one cycle later. Idle cycles between wait cycles do not reset the count.
- R6: A wait limit of zero never produces a wait abort.
- R7: The wait count returns to zero when `trdy_seen` or `phase_start` is sampled high. A wait cycle sampled together with either of them is not counted.
- R8: Each limit hit gives an `abort` pulse exactly one cycle long, and the count that hit restarts from zero. With limit 1, back-to-back events give back-to-back pulses.
- R9: The flags are sticky. A status write with `sts_we` high clears bit 0 (`retry_abort_flag`) and/or bit 1 (`wait_abort_flag`) wherever `sts_w1c` holds a one. A zero bit leaves that flag unchanged.
- R10: If a limit hit and a clearing write to the same flag fall in the same cycle, the flag ends up set.
- R11: `cfg_we` loads both limits at once. A new limit governs events from the cycle after the load; an event sampled in the load cycle is judged against the old limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cfg_we | input | 1 | Load both limit registers |
| cfg_retry_lim | input | 8 | Retry limit to load (0 = unlimited) |
| cfg_wait_lim | input | 8 | Ready-wait limit to load (0 = disabled) |
| sts_we | input | 1 | Status write strobe |
| sts_w1c | input | 2 | Write-one-to-clear mask: bit 0 retry flag, bit 1 wait flag |
| txn_start | input | 1 | A new transfer begins |
| txn_done | input | 1 | The current transfer completes |
| retry_seen | input | 1 | The target answered with a retry this cycle |
| phase_start | input | 1 | A new data phase begins |
| trdy_wait | input | 1 | The master is waiting for target ready this cycle |
| trdy_seen | input | 1 | Target ready is asserted this cycle |
| abort | output | 1 | One-cycle abort request |
| retry_abort_flag | output | 1 | Sticky: a transfer was aborted on the retry limit |
| wait_abort_flag | output | 1 | Sticky: a transfer was aborted on the ready-wait limit |

## Verification
Every result is due one clock after the inputs that cause it are sampled. A limit hit, a flag being set or cleared, a count being reset and a limit being loaded each show at the ports after that single edge. The driver task sets inputs at a falling edge, works out the expected `abort` and flag values for that cycle from the requirements, and queues them. The monitor takes the queued item one time unit after the next rising edge and compares it with the ports. Long runs at limits 0 and 255 check the boundary counts.

// File: rtl/xam_pkg.sv
// Package: shared widths and cause indices for the abort monitor.
// Assumes: cause index 0 is the retry check and index 1 is the ready-wait check.
package xam_pkg;
    parameter int unsigned CNT_W      = 8;
    localparam int unsigned NUM_CAUSES = 2;

    typedef enum logic [0:0] {
        CAUSE_RETRY = 1'b0,
        CAUSE_WAIT  = 1'b1
    } cause_e;
endpackage

// File: rtl/xam_limit_counter.sv
// Module: xam_limit_counter
// Counts increment events and reports a hit when the count reaches a
// programmable limit. A limit of zero never hits. The count restarts from zero
// after a hit and whenever clr is high (clr wins over inc).
// Assumes: synchronous active-low reset; lim is stable registered state.
module xam_limit_counter #(
    parameter int unsigned W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    input  logic [W-1:0] lim,
    output logic         hit
);
    logic [W-1:0] cnt;
    logic [W-1:0] cnt_nxt;

    // Next count and hit detection for this cycle's event.
    always_comb begin
        cnt_nxt = cnt + 1'b1;
        hit     = inc && !clr && (lim != '0) && (cnt_nxt == lim);
    end

    // Count register: cleared on reset, clear request or hit.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (clr || hit) cnt <= '0;
        else if (inc)        cnt <= cnt_nxt;
    end

    // R8
    hit_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> (cnt == '0));
    // R4 R7
    clr_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (cnt == '0));
    // R3 R6
    zero_lim_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lim == '0) |-> !hit);
endmodule

// File: rtl/xam_sticky_flags.sv
// Module: xam_sticky_flags
// Holds N sticky cause flags. A set event wins over a write-one-to-clear to
// the same bit in the same cycle; a zero in the write mask leaves a bit alone.
// Assumes: synchronous active-low reset.
module xam_sticky_flags #(
    parameter int unsigned N = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] set_evt,
    input  logic         we,
    input  logic [N-1:0] w1c,
    output logic [N-1:0] flags
);
    logic [N-1:0] clr_mask;

    // Bits the current write asks to clear.
    always_comb clr_mask = we ? w1c : '0;

    // Flag register: clear requested bits, then OR in new events.
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= (flags & ~clr_mask) | set_evt;
    end

    for (genvar i = 0; i < N; i++) begin : g_chk
        // R10
        set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set_evt[i] |=> flags[i]);
        // R9
        sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (flags[i] && !(we && w1c[i])) |=> flags[i]);
        // R9
        clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (we && w1c[i] && !set_evt[i]) |=> !flags[i]);
    end
endmodule

// File: rtl/xfer_abort_monitor.sv
// Module: xfer_abort_monitor (top)
// Watches a bus master's transfers: counts target retries per transfer and
// cycles spent waiting for target ready per data phase. A programmed limit
// hit raises a one-cycle abort and sets a sticky cause flag.
// Assumes: all inputs synchronous to clk; synchronous active-low reset.
module xfer_abort_monitor #(
    parameter int unsigned CNT_W = xam_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [CNT_W-1:0] cfg_retry_lim,
    input  logic [CNT_W-1:0] cfg_wait_lim,
    input  logic             sts_we,
    input  logic [1:0]       sts_w1c,
    input  logic             txn_start,
    input  logic             txn_done,
    input  logic             retry_seen,
    input  logic             phase_start,
    input  logic             trdy_wait,
    input  logic             trdy_seen,
    output logic             abort,
    output logic             retry_abort_flag,
    output logic             wait_abort_flag
);
    import xam_pkg::*;
    localparam int unsigned NC = NUM_CAUSES;

    logic [CNT_W-1:0] lim_q [NC];
    logic [NC-1:0]    clr_v;
    logic [NC-1:0]    inc_v;
    logic [NC-1:0]    hit_v;
    logic [NC-1:0]    flag_v;

    // Limit registers: both load on the configuration strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lim_q[CAUSE_RETRY] <= '0;
            lim_q[CAUSE_WAIT]  <= '0;
        end else if (cfg_we) begin
            lim_q[CAUSE_RETRY] <= cfg_retry_lim;
            lim_q[CAUSE_WAIT]  <= cfg_wait_lim;
        end
    end

    // Map bus events onto each counter's clear and increment.
    always_comb begin
        clr_v[CAUSE_RETRY] = txn_start || txn_done;
        inc_v[CAUSE_RETRY] = retry_seen;
        clr_v[CAUSE_WAIT]  = trdy_seen || phase_start;
        inc_v[CAUSE_WAIT]  = trdy_wait;
    end

    for (genvar c = 0; c < NC; c++) begin : g_cnt
        xam_limit_counter #(.W(CNT_W)) u_cnt (
            .clk   (clk),
            .rst_n (rst_n),
            .clr   (clr_v[c]),
            .inc   (inc_v[c]),
            .lim   (lim_q[c]),
            .hit   (hit_v[c])
        );
    end

    xam_sticky_flags #(.N(NC)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_evt (hit_v),
        .we      (sts_we),
        .w1c     (sts_w1c),
        .flags   (flag_v)
    );

    // Abort pulse: registered OR of this cycle's hits.
    always_ff @(posedge clk) begin
        if (!rst_n) abort <= 1'b0;
        else        abort <= |hit_v;
    end

    assign retry_abort_flag = flag_v[CAUSE_RETRY];
    assign wait_abort_flag  = flag_v[CAUSE_WAIT];

    // R2 R5
    abort_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        abort |-> (retry_abort_flag || wait_abort_flag));
    // R11
    lim_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_we |=> $stable(lim_q[CAUSE_RETRY]) && $stable(lim_q[CAUSE_WAIT]));
endmodule

// File: tb/sim_xfer_abort_monitor.sv
`timescale 1ns/1ps
module sim_xfer_abort_monitor;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_we = 0, sts_we = 0;
    logic [7:0] cfg_retry_lim = 0, cfg_wait_lim = 0;
    logic [1:0] sts_w1c = 0;
    logic txn_start = 0, txn_done = 0, retry_seen = 0;
    logic phase_start = 0, trdy_wait = 0, trdy_seen = 0;
    logic abort, retry_abort_flag, wait_abort_flag;

    always #5 clk = ~clk;

    xfer_abort_monitor u0 (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we),
        .cfg_retry_lim(cfg_retry_lim), .cfg_wait_lim(cfg_wait_lim),
        .sts_we(sts_we), .sts_w1c(sts_w1c),
        .txn_start(txn_start), .txn_done(txn_done), .retry_seen(retry_seen),
        .phase_start(phase_start), .trdy_wait(trdy_wait), .trdy_seen(trdy_seen),
        .abort(abort), .retry_abort_flag(retry_abort_flag),
        .wait_abort_flag(wait_abort_flag)
    );

    typedef struct packed { logic ab; logic [1:0] fl; } exp_t;
    exp_t  exp_q[$];
    string tag_q[$];
    int errors = 0, checks = 0;

    // Requirement-level model state.
    logic [7:0] m_rl = 0, m_wl = 0, m_rc = 0, m_wc = 0;
    logic [1:0] m_fl = 0;

    task automatic compare(input exp_t e, input string tag);
        checks++;
        if (abort !== e.ab || retry_abort_flag !== e.fl[0] || wait_abort_flag !== e.fl[1]) begin
            errors++;
            $display("FAIL %s: abort/rflag/wflag got %b%b%b expected %b%b%b", tag,
                     abort, retry_abort_flag, wait_abort_flag, e.ab, e.fl[0], e.fl[1]);
        end
    endtask

    // Driver: judge the driven inputs against the model, queue the result, advance.
    task automatic tick(input string tag);
        logic hr, hw;
        logic [7:0] nr, nw;
        exp_t e;
        nr = m_rc + 8'd1;
        nw = m_wc + 8'd1;
        hr = retry_seen && !(txn_start || txn_done) && m_rl != 0 && nr == m_rl;
        hw = trdy_wait && !(trdy_seen || phase_start) && m_wl != 0 && nw == m_wl;
        if (txn_start || txn_done || hr) m_rc = 0; else if (retry_seen) m_rc = nr;
        if (trdy_seen || phase_start || hw) m_wc = 0; else if (trdy_wait) m_wc = nw;
        m_fl = (m_fl & ~(sts_we ? sts_w1c : 2'b00)) | {hw, hr};
        if (cfg_we) begin m_rl = cfg_retry_lim; m_wl = cfg_wait_lim; end
        e.ab = hr | hw;
        e.fl = m_fl;
        exp_q.push_back(e);
        tag_q.push_back(tag);
        @(negedge clk);
        {cfg_we, sts_we, sts_w1c, txn_start, txn_done, retry_seen} = '0;
        {phase_start, trdy_wait, trdy_seen} = '0;
        cfg_retry_lim = 0; cfg_wait_lim = 0;
    endtask

    // Monitor: compare queued expectations just after each rising edge.
    always @(posedge clk) begin
        #1;
        if (exp_q.size() > 0) compare(exp_q.pop_front(), tag_q.pop_front());
    end

    task automatic cfg(input logic [7:0] rl, input logic [7:0] wl, input string tag);
        cfg_we = 1; cfg_retry_lim = rl; cfg_wait_lim = wl; tick(tag);
    endtask
    task automatic retries(input int n, input string tag);
        for (int i = 0; i < n; i++) begin retry_seen = 1; tick(tag); end
    endtask
    task automatic waits(input int n, input string tag);
        for (int i = 0; i < n; i++) begin trdy_wait = 1; tick(tag); end
    endtask

    int wd = 0;
    always @(posedge clk) begin
        wd++;
        if (wd > 20000) begin
            errors++; checks++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        compare('0, "R1 reset");
        rst_n = 1;
        // R1: zero limits after reset never abort
        retries(3, "R1"); waits(3, "R1");
        // R11 / R2: program limits then hit the retry limit
        cfg(8'd3, 8'd4, "R11");
        txn_start = 1; tick("R4");
        retries(3, "R2");
        tick("R8 pulse ends");
        retries(1, "R8 restart");
        // R4: completion and start clear the retry count
        txn_start = 1; tick("R4");
        retries(2, "R4"); txn_done = 1; tick("R4");
        retries(2, "R4"); txn_start = 1; retry_seen = 1; tick("R4 same-cycle");
        retries(3, "R4");
        // R9: zero bits no effect, one bit clears only its flag
        sts_we = 1; sts_w1c = 2'b00; tick("R9 zero");
        sts_we = 1; sts_w1c = 2'b10; tick("R9 other bit");
        sts_we = 1; sts_w1c = 2'b01; tick("R9 clear");
        // R5: wait limit with idle gaps
        waits(4, "R5");
        waits(1, "R5"); tick("R5 gap"); waits(3, "R5");
        // R7: ready and new phase clear the wait count
        waits(3, "R7"); trdy_seen = 1; tick("R7"); waits(3, "R7");
        phase_start = 1; trdy_wait = 1; tick("R7 same-cycle"); waits(4, "R7");
        sts_we = 1; sts_w1c = 2'b11; tick("R9 both");
        // R10: hit and clear in the same cycle
        txn_start = 1; tick("R10");
        retries(2, "R10");
        retry_seen = 1; sts_we = 1; sts_w1c = 2'b01; tick("R10");
        tick("R10 hold");
        // R11: load in the event cycle uses the old limit
        cfg(8'd2, 8'd0, "R11"); txn_start = 1; tick("R11");
        cfg_we = 1; cfg_retry_lim = 8'd1; retry_seen = 1; tick("R11 old limit");
        txn_start = 1; tick("R11");
        retries(3, "R8 back-to-back");
        // R6: wait limit zero
        waits(300, "R6");
        // R3 and R2 boundaries
        cfg(8'd0, 8'd0, "R3"); retries(300, "R3");
        cfg(8'd255, 8'd255, "R2"); txn_start = 1; tick("R2");
        retries(255, "R2 limit 255");
        phase_start = 1; tick("R5"); waits(255, "R5 limit 255");
        tick("end"); tick("end");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule